// File: doc/BRIEF.md
# Configurable-Format Serial Transmitter

This block turns words of up to nine bits into asynchronous serial frames on a single output line. A character-length control and a two-bit parity control select one of six frame layouts. Each layout has one start bit, then seven, eight or nine data bits sent least significant bit first, then an optional even or odd parity bit, then one stop bit. An inversion control flips every level the line carries, including the idle level, the start bit and the stop bit. The bit period is a number of system clocks set by a divisor input. An internal counter produces the bit-rate tick.

Words enter through a valid/ready port into a one-word holding register. `in_ready` is high while the block is enabled and the holding register is empty. A word is taken on each clock edge where both `in_valid` and `in_ready` are high. While `in_ready` is low the source keeps `in_valid` and `in_data` steady, and nothing is lost. Two plain flags report the state: `tdre` shows that the holding register is empty, and `tc` shows that the line has gone quiet with nothing waiting. The enable control shuts the block down: it stops the divider, drops any frame in progress and forces both flags high.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `tdre` and `tc` are 1, `txd` sits at the idle level (1 with `tx_inv` low), and `in_ready` is low while `en` is low.
- R2: A word is accepted on an edge with `in_valid` and `in_ready` both high. After that edge `tdre`, `tc` and `in_ready` are 0. If the shifter is idle, the word moves on the next edge, and after that edge `tdre` is 1 again.
- R3: With `len9`=0 and `par_en`=0 the frame is 10 bits: a 0 start bit, data bits 0..7 LSB first, then a 1 stop bit.
- R4: With `len9`=1 and `par_en`=0 the frame is 11 bits: a 0 start bit, data bits 0..8 LSB first, then a 1 stop bit.
- R5: With `len9`=0 and `par_en`=1 the frame is 10 bits: a 0 start bit, data bits 0..6 LSB first, a parity bit, then a 1 stop bit. The parity bit makes the count of ones across the data bits and itself even when `par_odd`=0 and odd when `par_odd`=1.
- R6: With `len9`=1 and `par_en`=1 the frame is 11 bits: a 0 start bit, data bits 0..7 LSB first, a parity bit as in R5, then a 1 stop bit.
- R7: Each bit lasts `divisor` clocks, and a divisor of 0 acts as 1. The start bit appears on `txd` right after the edge that moves the word into the shifter.
- R8: When `tx_inv` is 1, `txd` is the complement of every level in R3 to R7, including the idle level.
- R9: `tc` rises after the edge that ends a stop bit when no word is waiting. If a word is waiting, its start bit follows the previous stop bit with no idle gap, and `tc` stays 0 in between.
- R10: While `en` is 0 the block refuses words (`in_ready`=0), drops any frame in progress, holds `txd` at the idle level and forces `tdre` and `tc` to 1. No word offered while `en` is 0 is sent once `en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Block enable |
| tx_inv | input | 1 | Invert every level on `txd` |
| len9 | input | 1 | Long character (9 bits of payload incl. parity) |
| par_en | input | 1 | Replace the top data bit with a parity bit |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| divisor | input | 16 | System clocks per bit (0 acts as 1) |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Holding register can take a word |
| in_data | input | 9 | Word to send; unused top bits are ignored |
| txd | output | 1 | Serial line |
| tdre | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete, line quiet |

## Verification
The case that is hardest to reach from the ports is a second word waiting in the holding register at the exact edge where the stop bit ends. If it is late by even one cycle, the bench sees the idle gap and a `tc` pulse instead of a seamless frame. The bench reaches this case by keeping `in_valid` high through the cycle in which the first word leaves the holding register. The second word is then taken on the very next edge, early in the first frame. The other corner is turning the block off partway through a frame while words are still being offered. The bench does this and then checks that the line and the flags come back clean.

// File: rtl/uft_pkg.sv
`timescale 1ns/1ps
package uft_pkg;
  typedef struct packed {
    logic len9;
    logic par_en;
    logic par_odd;
  } fmt_t;

  // number of data bits actually carried for a given word width and format
  function automatic int data_bits(input int word_w, input fmt_t f);
    return word_w - (f.len9 ? 0 : 1) - (f.par_en ? 1 : 0);
  endfunction
endpackage

// File: rtl/uft_baud.sv
`timescale 1ns/1ps
module uft_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] top;

  assign top  = (divisor == '0) ? '0 : divisor - 1'b1;
  assign tick = run && (cnt == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (!run || restart || tick) cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uft_hold.sv
`timescale 1ns/1ps
module uft_hold #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  input  logic              frame_end,
  output logic              in_ready,
  output logic              full,
  output logic [DATA_W-1:0] word,
  output logic              tc
);
  logic accept;

  assign in_ready = en && !full;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
      tc   <= 1'b1;
    end else if (!en) begin
      full <= 1'b0;
      tc   <= 1'b1;
    end else begin
      if (accept) begin
        full <= 1'b1;
        word <= in_data;
      end else if (take) begin
        full <= 1'b0;
      end
      if (accept)                 tc <= 1'b0;
      else if (frame_end && !full) tc <= 1'b1;
    end
  end
endmodule

// File: rtl/uft_shift.sv
`timescale 1ns/1ps
module uft_shift
  import uft_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int FRAME_W = DATA_W + 2,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  fmt_t              fmt,
  input  logic              word_full,
  input  logic [DATA_W-1:0] word,
  input  logic              tick,
  output logic              busy,
  output logic              line,
  output logic              load,
  output logic              frame_end
);
  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] frame_next;
  logic [CNT_W-1:0]   bitcnt;
  logic [CNT_W-1:0]   nbits_q;
  logic [CNT_W-1:0]   nbits_next;

  // assemble start, data, optional parity and stop in one vector
  always_comb begin
    int              nd;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] kept;
    logic            par;
    nd         = data_bits(DATA_W, fmt);
    mask       = ~({DATA_W{1'b1}} << nd);
    kept       = word & mask;
    par        = (^kept) ^ fmt.par_odd;
    frame_next = ({FRAME_W{1'b1}} << (nd + (fmt.par_en ? 2 : 1)))
               | (FRAME_W'(kept) << 1)
               | (FRAME_W'(par && fmt.par_en) << (nd + 1));
    nbits_next = CNT_W'(nd + (fmt.par_en ? 3 : 2));
  end

  assign line      = shreg[0];
  assign frame_end = busy && tick && (bitcnt == nbits_q - 1'b1);
  assign load      = en && word_full && (!busy || frame_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      shreg   <= '1;
      bitcnt  <= '0;
      nbits_q <= '0;
    end else if (!en) begin
      busy   <= 1'b0;
      shreg  <= '1;
      bitcnt <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      shreg   <= frame_next;
      bitcnt  <= '0;
      nbits_q <= nbits_next;
    end else if (frame_end) begin
      busy  <= 1'b0;
      shreg <= '1;
    end else if (tick) begin
      shreg  <= {1'b1, shreg[FRAME_W-1:1]};
      bitcnt <= bitcnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
`timescale 1ns/1ps
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tx_inv,
  input  logic              len9,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              txd,
  output logic              tdre,
  output logic              tc
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  fmt_t              fmt;
  logic              word_full;
  logic [DATA_W-1:0] word;
  logic              busy;
  logic              line;
  logic              load;
  logic              frame_end;
  logic              tick;

  assign fmt = '{len9: len9, par_en: par_en, par_odd: par_odd};

  uft_baud #(.DIV_W(DIV_W)) i_baud (
    .clk(clk), .rst_n(rst_n), .run(busy && en), .restart(load),
    .divisor(divisor), .tick(tick)
  );

  uft_hold #(.DATA_W(DATA_W)) i_hold (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
    .in_data(in_data), .take(load), .frame_end(frame_end),
    .in_ready(in_ready), .full(word_full), .word(word), .tc(tc)
  );

  uft_shift #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt), .word_full(word_full),
    .word(word), .tick(tick), .busy(busy), .line(line), .load(load),
    .frame_end(frame_end)
  );

  assign txd  = line ^ tx_inv;
  assign tdre = !word_full;
endmodule

// File: rtl/uft_checker.sv
`timescale 1ns/1ps
module uft_checker (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic tx_inv,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic tdre,
  input logic tc,
  input logic busy
);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!tdre && !tc && !in_ready));

  p_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tdre && !busy) |=> tdre);

  p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (txd == tx_inv));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (txd != tx_inv));

  p_tc_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tc);

  p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> (tdre && tc && !in_ready && !busy));
endmodule

bind uart_frame_tx uft_checker i_uft_checker (
  .clk(clk), .rst_n(rst_n), .en(en), .tx_inv(tx_inv),
  .in_valid(in_valid), .in_ready(in_ready), .txd(txd),
  .tdre(tdre), .tc(tc), .busy(busy)
);

// File: tb/test_uart_frame_tx.sv
`timescale 1ns/1ps
module test_uart_frame_tx;
  localparam int DATA_W = 9;
  localparam int DIV_W  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, tx_inv = 1'b0, len9 = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic [DIV_W-1:0]  divisor = 16'd1;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, txd, tdre, tc;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_frame_tx i_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .en(en), .tx_inv(tx_inv), .len9(len9),
    .par_en(par_en), .par_odd(par_odd), .divisor(divisor),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .txd(txd), .tdre(tdre), .tc(tc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_bit(input int k, input logic [8:0] d,
                                 input bit l9, input bit pe, input bit po);
    int nd;
    bit par;
    nd  = (l9 ? 9 : 8) - (pe ? 1 : 0);
    par = po;
    for (int i = 0; i < nd; i++) par ^= d[i];
    if (k == 0)             return 1'b0;
    if (k <= nd)            return d[k-1];
    if (pe && k == nd + 1)  return par;
    return 1'b1;
  endfunction

  function automatic string ftag(input bit l9, input bit pe);
    if (l9) return pe ? "R6" : "R4";
    return pe ? "R5" : "R3";
  endfunction

  // frame starts at the current negedge; one check per frame bit
  task automatic run_frame(input logic [8:0] d, input int deff, input string req);
    int n;
    bit e, ok;
    int act;
    n = len9 ? 11 : 10;
    for (int k = 0; k < n; k++) begin
      e   = exp_bit(k, d, len9, par_en, par_odd) ^ tx_inv;
      ok  = 1;
      act = e;
      for (int c = 0; c < deff; c++) begin
        if (txd !== e || tc !== 1'b0) begin ok = 0; act = txd; end
        @(negedge clk);
      end
      chk(ok, req, act, e);
    end
  endtask

  task automatic send_one(input logic [8:0] d, input int div, input string req);
    divisor = DIV_W'(div);
    in_valid = 1'b1;
    in_data  = d;
    chk(in_ready === 1'b1, "R2", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(tdre === 1'b0 && tc === 1'b0 && in_ready === 1'b0, "R2", {tdre, tc}, 0);
    @(negedge clk);
    chk(tdre === 1'b1, "R2", tdre, 1);
    run_frame(d, (div == 0) ? 1 : div, req);
    chk(tc === 1'b1 && tdre === 1'b1 && txd === ~tx_inv, "R9",
        {tc, tdre, txd}, {2'b11, ~tx_inv});
    @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual hung expected done");
    report();
  end

  initial begin
    logic [8:0] pat;
    int divs[3] = '{1, 2, 5};
    repeat (3) @(negedge clk);
    chk(tdre === 1'b1 && tc === 1'b1 && txd === 1'b1, "R1", {tdre, tc, txd}, 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tdre === 1'b1 && tc === 1'b1 && txd === 1'b1, "R1", {tdre, tc, txd}, 7);
    chk(in_ready === 1'b0, "R1", in_ready, 0);
    tx_inv = 1'b1;
    @(negedge clk);
    chk(txd === 1'b0, "R8", txd, 0);
    tx_inv = 1'b0;
    en = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1 && txd === 1'b1, "R2", in_ready, 1);

    // exhaustive data sweep over each format, inversion alternating
    for (int f = 0; f < 4; f++) begin
      len9   = f[1];
      par_en = f[0];
      for (int v = 0; v < 512; v++) begin
        par_odd = v[3];
        tx_inv  = v[5];
        @(negedge clk);
        send_one(9'(v), 1, ftag(len9, par_en));
      end
    end

    // bit timing sweep over divisors and patterns
    for (int f = 0; f < 4; f++) begin
      len9   = f[1];
      par_en = f[0];
      for (int di = 0; di < 3; di++) begin
        for (int p = 0; p < 6; p++) begin
          pat     = 9'((p * 181 + f * 77) ^ (p << 6));
          par_odd = p[0];
          tx_inv  = p[1];
          send_one(pat, divs[di], "R7");
        end
      end
    end
    tx_inv = 1'b0; len9 = 1'b0; par_en = 1'b0;
    send_one(9'h0A5, 0, "R7");

    // back-to-back: second word waits, no gap between frames
    for (int f = 0; f < 4; f++) begin
      len9    = f[1];
      par_en  = f[0];
      par_odd = f[0];
      tx_inv  = f[1];
      divisor = 16'd3;
      in_valid = 1'b1;
      in_data  = 9'h1C6;
      @(negedge clk);
      in_data = 9'h039;
      chk(in_ready === 1'b0, "R2", in_ready, 0);
      @(negedge clk);
      fork
        begin
          @(negedge clk);
          in_valid = 1'b0;
        end
        run_frame(9'h1C6, 3, "R9");
      join
      run_frame(9'h039, 3, "R9");
      chk(tc === 1'b1 && txd === ~tx_inv, "R9", {tc, txd}, {1'b1, ~tx_inv});
      @(negedge clk);
    end

    // disable partway through a frame, then offer words while off
    tx_inv = 1'b0; len9 = 1'b0; par_en = 1'b0;
    divisor  = 16'd4;
    in_valid = 1'b1;
    in_data  = 9'h03C;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(tc === 1'b0 && tdre === 1'b1, "R9", tc, 0);
    en = 1'b0;
    @(negedge clk);
    chk(tdre === 1'b1 && tc === 1'b1 && txd === 1'b1, "R10", {tdre, tc, txd}, 7);
    in_valid = 1'b1;
    in_data  = 9'h000;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(in_ready === 1'b0 && txd === 1'b1 && tdre === 1'b1, "R10",
          {in_ready, txd, tdre}, 3);
    end
    in_valid = 1'b0;
    en = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(tdre === 1'b1 && tc === 1'b1 && txd === 1'b1, "R10", {tdre, tc, txd}, 7);
    end
    send_one(9'h0F0, 2, "R10");

    report();
  end
endmodule